// File: doc/BRIEF.md
# Code Segment Load Privilege Checker

This block judges whether a code-segment descriptor may become the new code segment during a far jump, call or return. The caller presents the descriptor's attribute bits, the target selector, the privilege level to be checked against the selector, the current privilege level and a flag that says whether 64-bit mode is active. It raises a one-cycle strobe (`check_valid`) to start a check.

One clock later the block returns a verdict. The verdict is either pass, or a fault with its vector and error code. Every rule is evaluated in parallel, and a fixed priority picks the first rule that fails. All privilege and type rules report a general-protection fault. A missing descriptor reports the separate segment-not-present fault, and it does so only when every other rule is satisfied.

A descriptor that asks for 64-bit code while 64-bit mode is off does not fault. Instead it raises a diagnostic flag that the surrounding logic may log.

Top module: `cs_load_checker`

## Requirements
- R1: `result_valid` is high in exactly the cycle after each cycle in which `check_valid` is high, and low otherwise. While no check is made, `fault`, `fault_vec`, `err_code` and `lmode_warn` keep their last values.
- R2: A descriptor whose valid bit is 0, whose S bit is 0, or whose type bit 3 is 0 (data) yields a fault with vector 13 (general protection).
- R3: With type bit 3 equal to 1, `desc_l`=1, `lm_active`=1 and `desc_db`=1 together yield a fault with vector 13.
- R4: `desc_l`=1 with `lm_active`=0 causes no fault by itself. `lmode_warn` is 1 exactly when that holds and the R2 rule passes, whatever any later rule decides.
- R5: For a non-conforming code segment (type bit 2 equal to 0), a DPL not equal to CPL yields a fault with vector 13.
- R6: For a non-conforming code segment, a requested level greater than CPL yields a fault with vector 13. A requested level of 0 never triggers this rule.
- R7: For a conforming code segment (type bit 2 equal to 1), a DPL greater than CPL yields a fault with vector 13.
- R8: A present bit of 0 yields a fault with vector 11 (segment not present) only when rules R2, R3, R5, R6 and R7 all pass. Otherwise the vector is 13.
- R9: On a fault, `err_code` equals the selector with bits 1:0 cleared. On a pass, `fault`, `fault_vec` and `err_code` are all 0.
- R10: After reset, `result_valid`, `fault`, `fault_vec`, `err_code` and `lmode_warn` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| check_valid | input | 1 | Starts a check on the current inputs |
| desc_valid | input | 1 | Descriptor valid bit |
| desc_s | input | 1 | Descriptor S bit (1 = code/data, 0 = system) |
| desc_type | input | 4 | Descriptor type field |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| desc_l | input | 1 | 64-bit code bit |
| desc_db | input | 1 | Default operand size bit |
| sel | input | 16 | Target selector |
| req_pl | input | 2 | Requested privilege level to check |
| cpl | input | 2 | Current privilege level |
| lm_active | input | 1 | 64-bit mode active |
| result_valid | output | 1 | Verdict strobe, one cycle after `check_valid` |
| fault | output | 1 | 1 = load refused |
| fault_vec | output | 8 | 13 = general protection, 11 = not present, 0 = pass |
| err_code | output | 16 | Selector with bits 1:0 cleared on a fault, else 0 |
| lmode_warn | output | 1 | Diagnostic: 64-bit code requested outside 64-bit mode |

## Verification
The bench sweeps every combination of the attribute bits, the two privilege levels and the mode flag. This lets it catch rule-ordering mistakes. A design that checks presence too early would report vector 11 for descriptors that are also privilege violations. A design that swaps the conforming and non-conforming rules would pass outer-ring callers into non-conforming code, or refuse legal conforming entries. The sweep also covers a requested level of 0 against every CPL, a set L bit with 64-bit mode off (which must warn, not fault), and selectors with nonzero low bits, where a design that forgets to mask them would leak them into the error code.

// File: rtl/cs_chk_pkg.sv
package cs_chk_pkg;

   localparam int          VEC_W  = 8;
   localparam logic [7:0]  VEC_GP = 8'd13;
   localparam logic [7:0]  VEC_NP = 8'd11;

   // rule order matches reporting priority
   typedef enum logic [2:0] {
      RULE_NONE,
      RULE_KIND,
      RULE_MODE,
      RULE_NC_DPL,
      RULE_NC_RPL,
      RULE_C_DPL,
      RULE_ABSENT
   } rule_e;

   typedef struct packed {
      logic kind;
      logic mode;
      logic nc_dpl;
      logic nc_rpl;
      logic c_dpl;
      logic absent;
   } rule_hits_t;

endpackage

// File: rtl/cs_type_decode.sv
module cs_type_decode #(
   parameter int TYPE_W   = 4,
   parameter int CODE_BIT = 3,
   parameter int CONF_BIT = 2
) (
   input  logic [TYPE_W-1:0] type_i,
   output logic              is_code_o,
   output logic              is_conf_o
);

   localparam logic [TYPE_W-1:0] CODE_MASK = TYPE_W'(1) << CODE_BIT;
   localparam logic [TYPE_W-1:0] CONF_MASK = TYPE_W'(1) << CONF_BIT;

   if (CODE_BIT >= TYPE_W || CONF_BIT >= TYPE_W) begin : g_bad_bits
      $error("cs_type_decode: type bit index outside the type field");
   end
   if (CODE_BIT == CONF_BIT) begin : g_same_bits
      $error("cs_type_decode: code and conforming bits must differ");
   end

   always_comb begin
      is_code_o = |(type_i & CODE_MASK);
      is_conf_o = |(type_i & CONF_MASK);
   end

endmodule

// File: rtl/cs_priv_rules.sv
module cs_priv_rules
   import cs_chk_pkg::*;
#(
   parameter int PL_W   = 2,
   parameter bit LONG_EN = 1'b1
) (
   input  logic            desc_valid_i,
   input  logic            desc_s_i,
   input  logic            is_code_i,
   input  logic            is_conf_i,
   input  logic [PL_W-1:0] dpl_i,
   input  logic            present_i,
   input  logic            l_i,
   input  logic            db_i,
   input  logic            lm_i,
   input  logic [PL_W-1:0] req_pl_i,
   input  logic [PL_W-1:0] cpl_i,
   output rule_hits_t      hits_o,
   output logic            warn_o
);

   logic kind_bad;

   always_comb begin
      kind_bad        = !desc_valid_i || !desc_s_i || !is_code_i;
      hits_o.kind     = kind_bad;
      hits_o.nc_dpl   = !is_conf_i && (dpl_i != cpl_i);
      hits_o.nc_rpl   = !is_conf_i && (req_pl_i > cpl_i);
      hits_o.c_dpl    =  is_conf_i && (dpl_i > cpl_i);
      hits_o.absent   = !present_i;
   end

   if (LONG_EN) begin : g_long
      always_comb begin
         hits_o.mode = l_i && lm_i && db_i;
         warn_o      = !kind_bad && l_i && !lm_i;
      end
   end else begin : g_legacy
      always_comb begin
         hits_o.mode = 1'b0;
         warn_o      = 1'b0;
      end
   end

endmodule

// File: rtl/cs_fault_prio.sv
module cs_fault_prio
   import cs_chk_pkg::*;
(
   input  rule_hits_t       hits_i,
   output rule_e            first_o,
   output logic             fault_o,
   output logic [VEC_W-1:0] vec_o
);

   always_comb begin
      if      (hits_i.kind)   first_o = RULE_KIND;
      else if (hits_i.mode)   first_o = RULE_MODE;
      else if (hits_i.nc_dpl) first_o = RULE_NC_DPL;
      else if (hits_i.nc_rpl) first_o = RULE_NC_RPL;
      else if (hits_i.c_dpl)  first_o = RULE_C_DPL;
      else if (hits_i.absent) first_o = RULE_ABSENT;
      else                    first_o = RULE_NONE;

      fault_o = (first_o != RULE_NONE);
      unique case (first_o)
         RULE_NONE:   vec_o = '0;
         RULE_ABSENT: vec_o = VEC_NP;
         default:     vec_o = VEC_GP;
      endcase
   end

endmodule

// File: rtl/cs_load_checker.sv
module cs_load_checker
   import cs_chk_pkg::*;
#(
   parameter int SEL_W    = 16,
   parameter int PL_W     = 2,
   parameter int TYPE_W   = 4,
   parameter int CODE_BIT = 3,
   parameter int CONF_BIT = 2,
   parameter bit LONG_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              check_valid,
   input  logic              desc_valid,
   input  logic              desc_s,
   input  logic [TYPE_W-1:0] desc_type,
   input  logic [PL_W-1:0]   desc_dpl,
   input  logic              desc_present,
   input  logic              desc_l,
   input  logic              desc_db,
   input  logic [SEL_W-1:0]  sel,
   input  logic [PL_W-1:0]   req_pl,
   input  logic [PL_W-1:0]   cpl,
   input  logic              lm_active,
   output logic              result_valid,
   output logic              fault,
   output logic [VEC_W-1:0]  fault_vec,
   output logic [SEL_W-1:0]  err_code,
   output logic              lmode_warn
);

   localparam logic [SEL_W-1:0] ERR_MASK = {{(SEL_W-PL_W){1'b1}}, {PL_W{1'b0}}};

   if (SEL_W <= PL_W) begin : g_bad_sel
      $error("cs_load_checker: selector narrower than its privilege field");
   end

   logic             is_code, is_conf;
   rule_hits_t       hits;
   logic             warn_d;
   rule_e            first_rule;
   logic             fault_d;
   logic [VEC_W-1:0] vec_d;
   logic [SEL_W-1:0] err_d;

   cs_type_decode #(
      .TYPE_W   (TYPE_W),
      .CODE_BIT (CODE_BIT),
      .CONF_BIT (CONF_BIT)
   ) u_decode (
      .type_i    (desc_type),
      .is_code_o (is_code),
      .is_conf_o (is_conf)
   );

   cs_priv_rules #(
      .PL_W    (PL_W),
      .LONG_EN (LONG_EN)
   ) u_rules (
      .desc_valid_i (desc_valid),
      .desc_s_i     (desc_s),
      .is_code_i    (is_code),
      .is_conf_i    (is_conf),
      .dpl_i        (desc_dpl),
      .present_i    (desc_present),
      .l_i          (desc_l),
      .db_i         (desc_db),
      .lm_i         (lm_active),
      .req_pl_i     (req_pl),
      .cpl_i        (cpl),
      .hits_o       (hits),
      .warn_o       (warn_d)
   );

   cs_fault_prio u_prio (
      .hits_i  (hits),
      .first_o (first_rule),
      .fault_o (fault_d),
      .vec_o   (vec_d)
   );

   always_comb begin
      err_d = fault_d ? (sel & ERR_MASK) : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_valid <= 1'b0;
         fault        <= 1'b0;
         fault_vec    <= '0;
         err_code     <= '0;
         lmode_warn   <= 1'b0;
      end else begin
         result_valid <= check_valid;
         if (check_valid) begin
            fault      <= fault_d;
            fault_vec  <= vec_d;
            err_code   <= err_d;
            lmode_warn <= warn_d;
         end
      end
   end

   assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
      check_valid |=> result_valid);
   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !check_valid |=> (!result_valid && $stable(fault_vec) && $stable(err_code)));
   assert_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (check_valid && (!desc_valid || !desc_s)) |=> (fault && fault_vec == VEC_GP));
   assert_absent_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (check_valid && !desc_present) |=> fault);
   assert_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && fault) |-> (fault_vec == VEC_GP || fault_vec == VEC_NP));
   assert_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (check_valid ##1 fault) |->
         (err_code[PL_W-1:0] == '0 && err_code[SEL_W-1:PL_W] == $past(sel[SEL_W-1:PL_W])));
   assert_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (result_valid && !fault) |-> (fault_vec == '0 && err_code == '0));

endmodule

// File: tb/cs_load_checker_tb.sv
`timescale 1ns/1ps
module cs_load_checker_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        check_valid = 1'b0;
   logic        desc_valid = 1'b0, desc_s = 1'b0, desc_present = 1'b0;
   logic        desc_l = 1'b0, desc_db = 1'b0, lm_active = 1'b0;
   logic [3:0]  desc_type = '0;
   logic [1:0]  desc_dpl = '0, req_pl = '0, cpl = '0;
   logic [15:0] sel = '0;
   logic        result_valid, fault, lmode_warn;
   logic [7:0]  fault_vec;
   logic [15:0] err_code;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cs_load_checker u_dut (
      .clk(clk), .rst_n(rst_n), .check_valid(check_valid),
      .desc_valid(desc_valid), .desc_s(desc_s), .desc_type(desc_type),
      .desc_dpl(desc_dpl), .desc_present(desc_present), .desc_l(desc_l),
      .desc_db(desc_db), .sel(sel), .req_pl(req_pl), .cpl(cpl),
      .lm_active(lm_active), .result_valid(result_valid), .fault(fault),
      .fault_vec(fault_vec), .err_code(err_code), .lmode_warn(lmode_warn)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   logic [7:0]  e_vec;
   logic [15:0] e_err;
   logic        e_warn;
   string       e_tag;

   task automatic expect_for(input bit va, input bit s, input logic [3:0] t,
                             input logic [1:0] dpl, input bit p, input bit l,
                             input bit db, input bit lm, input logic [1:0] rq,
                             input logic [1:0] cp, input logic [15:0] sv);
      bit kb;
      kb = !va || !s || !t[3];
      if (kb)                           begin e_vec = 8'd13; e_tag = "R2"; end
      else if (l && lm && db)           begin e_vec = 8'd13; e_tag = "R3"; end
      else if (!t[2] && dpl != cp)      begin e_vec = 8'd13; e_tag = "R5"; end
      else if (!t[2] && rq > cp)        begin e_vec = 8'd13; e_tag = "R6"; end
      else if (t[2] && dpl > cp)        begin e_vec = 8'd13; e_tag = "R7"; end
      else if (!p)                      begin e_vec = 8'd11; e_tag = "R8"; end
      else                              begin e_vec = 8'd0;  e_tag = "R9"; end
      e_err  = (e_vec != 0) ? {sv[15:2], 2'b00} : 16'h0;
      e_warn = !kb && l && !lm;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int idx;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 result_valid", result_valid, 0);
      check("R10 fault", fault, 0);
      check("R10 fault_vec", fault_vec, 0);
      check("R10 err_code", err_code, 0);
      check("R10 lmode_warn", lmode_warn, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle after reset", result_valid, 0);

      idx = 0;
      for (int va = 0; va < 2; va++)
       for (int s = 0; s < 2; s++)
        for (int t = 0; t < 16; t++)
         for (int dpl = 0; dpl < 4; dpl++)
          for (int p = 0; p < 2; p++)
           for (int l = 0; l < 2; l++)
            for (int db = 0; db < 2; db++)
             for (int lm = 0; lm < 2; lm++)
              for (int rq = 0; rq < 4; rq++)
               for (int cp = 0; cp < 4; cp++) begin
                  desc_valid = va[0]; desc_s = s[0]; desc_type = t[3:0];
                  desc_dpl = dpl[1:0]; desc_present = p[0]; desc_l = l[0];
                  desc_db = db[0]; lm_active = lm[0]; req_pl = rq[1:0];
                  cpl = cp[1:0];
                  sel = 16'(idx * 16'h9E37 + 3);
                  check_valid = 1'b1;
                  expect_for(va[0], s[0], t[3:0], dpl[1:0], p[0], l[0], db[0],
                             lm[0], rq[1:0], cp[1:0], sel);
                  @(negedge clk);
                  check("R1 strobe", result_valid, 1);
                  check({e_tag, " verdict"}, {fault, fault_vec}, {(e_vec != 0), e_vec});
                  check("R9 err_code", err_code, e_err);
                  check("R4 lmode_warn", lmode_warn, e_warn);
                  idx++;
               end

      // R1: hold while idle; change inputs to a clean pass
      check_valid = 1'b0;
      desc_valid = 1; desc_s = 1; desc_type = 4'hA; desc_dpl = 0; cpl = 0;
      req_pl = 0; desc_present = 1; desc_l = 0;
      @(negedge clk);
      check("R1 no strobe", result_valid, 0);
      check("R1 hold vec", fault_vec, e_vec);
      check("R1 hold err", err_code, e_err);
      @(negedge clk);
      check("R1 still idle", result_valid, 0);

      // R6: requested level 0 with non-conforming segment at each CPL
      for (int cp = 0; cp < 4; cp++) begin
         desc_dpl = cp[1:0]; cpl = cp[1:0]; req_pl = 2'd0; check_valid = 1'b1;
         @(negedge clk);
         check("R6 zero request passes", {fault, fault_vec}, 9'd0);
      end
      check_valid = 1'b0;
      @(negedge clk);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule